// File: doc/BRIEF.md
# Playback Format Decoder and Period Counter

This block sits between a DMA byte stream and an audio sink. It turns a playback format byte into a sample rate in hertz, a channel count, a sample encoding and a byte-count shift. It also flags settings that cannot be played. While playback runs it holds the DMA request high. It counts the bytes the DMA side accepts, and when that count reaches a programmed period it emits a one-cycle interrupt pulse.

The period length in bytes is the 16-bit base count shifted left by the decoded count shift. The shift is what lets one base count give the same number of sample frames for every encoding. A mode bit widens the encoding field from two bits to three, which makes the big-endian and reserved codes reachable. The decode is re-evaluated every cycle, so a format change while playing takes effect at once. That change does not disturb the running byte count unless it stops playback.

Top module: `pbfmt_pacer`

## Requirements
- R1: During and right after a synchronous reset, `dreq`, `period_irq` and `cfg_err` are 0.
- R2: Bit 0 of the format byte selects the rate table and bits 3:1 index it, with the result on `rate_hz` one cycle after the inputs. Table 0 holds 8000, 16000, 27420, 32000, -, -, 48000, 9000. Table 1 holds 5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620. The two dashes give `rate_hz` = 0.
- R3: Format bit 4 drives `stereo` (1 means two channels).
- R4: With `ext_mode` = 1 the encoding code is format bits 7:5. With `ext_mode` = 0 it is {0, bits 6:5}, so bit 7 is ignored.
- R5: `sample_enc` reports the encoding as follows. Code 0 gives 0 (unsigned 8-bit). Code 1 gives 1 (mu-law). Code 3 gives 2 (A-law). Code 2 gives 3 (signed 16-bit little-endian). Code 6 gives 4 (signed 16-bit big-endian). Every other code gives 7.
- R6: `cfg_err` is 1 when the code is 4, 5 or 7, or when the rate entry is a dash.
- R7: `byte_shift` is 0 for mono and 1 for stereo with 8-bit or companded encodings. It is 1 for mono and 2 for stereo with 16-bit encodings. It is 0 when the encoding is invalid.
- R8: `dreq` goes to 1 one cycle after `play_en` = 1 with no error. It goes to 0 one cycle after `play_en` = 0 or an error. Every 0-to-1 transition restarts the byte count at 0.
- R9: With `irq_en` = 1, the byte accepted while `dreq` = 1 that brings the count to ({`base_hi`,`base_lo`} << `byte_shift`) raises `period_irq` for one cycle in the next cycle. The same byte restarts the count at 0.
- R10: With `irq_en` = 0, accepted bytes keep accumulating and `period_irq` stays 0.
- R11: A format change that keeps the setting valid while `dreq` = 1 leaves `dreq` high and keeps the byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fmt_byte | input | 8 | Playback format byte |
| ext_mode | input | 1 | Extended mode: three-bit encoding field |
| base_hi | input | 8 | Upper byte of the period base count |
| base_lo | input | 8 | Lower byte of the period base count |
| irq_en | input | 1 | Enable for the period interrupt |
| play_en | input | 1 | Playback enable |
| byte_ack | input | 1 | One byte accepted by the DMA side this cycle |
| rate_hz | output | 16 | Decoded sample rate, 0 if invalid |
| stereo | output | 1 | Two channels |
| sample_enc | output | 3 | Decoded encoding (see R5) |
| byte_shift | output | 2 | Byte-count shift (see R7) |
| cfg_err | output | 1 | Unplayable setting |
| dreq | output | 1 | DMA request, high while playing |
| period_irq | output | 1 | One-cycle period-complete pulse |

## Verification
Decode faults show up on `rate_hz`, `sample_enc`, `byte_shift` and `cfg_err` one cycle after the format byte changes. A table sweep over all sixteen rate slots and every encoding code in both modes exposes them right away. A wrong byte count, threshold or restart point shows up only at the end of a period: `period_irq` arrives early, late or not at all. Because of this, the bench counts exact period lengths for several shifts and checks across restarts, mid-period format changes and error stops. A wrong run state shows on `dreq` within one cycle of the enable or error changing.

// File: rtl/pbfmt_pkg.sv
package pbfmt_pkg;

    localparam int BYTE_W  = 8;
    localparam int BASE_W  = 2 * BYTE_W;
    localparam int SHIFT_W = 2;
    localparam int CNT_W   = BASE_W + SHIFT_W;
    localparam int RATE_W  = 16;
    localparam int CODE_W  = 3;

    typedef enum logic [2:0] {
        ENC_U8    = 3'd0,
        ENC_ULAW  = 3'd1,
        ENC_ALAW  = 3'd2,
        ENC_S16LE = 3'd3,
        ENC_S16BE = 3'd4,
        ENC_NONE  = 3'd7
    } enc_e;

    typedef struct packed {
        logic [RATE_W-1:0]  rate_hz;
        logic               stereo;
        enc_e               enc;
        logic [SHIFT_W-1:0] shift;
        logic               err;
    } pb_cfg_t;

    localparam pb_cfg_t CFG_RESET = '{
        rate_hz: '0,
        stereo:  1'b0,
        enc:     ENC_NONE,
        shift:   '0,
        err:     1'b0
    };

    // Rate in Hz for a crystal select and rate index; 0 marks an unusable slot.
    function automatic logic [RATE_W-1:0] rate_of(input logic xtal, input logic [2:0] sel);
        logic [RATE_W-1:0] r;
        case ({xtal, sel})
            4'b0_000: r = 16'd8000;
            4'b0_001: r = 16'd16000;
            4'b0_010: r = 16'd27420;
            4'b0_011: r = 16'd32000;
            4'b0_110: r = 16'd48000;
            4'b0_111: r = 16'd9000;
            4'b1_000: r = 16'd5510;
            4'b1_001: r = 16'd11025;
            4'b1_010: r = 16'd18900;
            4'b1_011: r = 16'd22050;
            4'b1_100: r = 16'd37800;
            4'b1_101: r = 16'd44100;
            4'b1_110: r = 16'd33075;
            4'b1_111: r = 16'd6620;
            default:  r = '0;
        endcase
        return r;
    endfunction

    function automatic enc_e enc_of(input logic [CODE_W-1:0] code);
        enc_e e;
        case (code)
            3'd0:    e = ENC_U8;
            3'd1:    e = ENC_ULAW;
            3'd2:    e = ENC_S16LE;
            3'd3:    e = ENC_ALAW;
            3'd6:    e = ENC_S16BE;
            default: e = ENC_NONE;
        endcase
        return e;
    endfunction

    // Bytes per counted unit, as a left shift of the base count.
    function automatic logic [SHIFT_W-1:0] shift_of(input enc_e e, input logic st);
        logic [SHIFT_W-1:0] s;
        case (e)
            ENC_U8, ENC_ULAW, ENC_ALAW: s = st ? 2'd1 : 2'd0;
            ENC_S16LE, ENC_S16BE:       s = st ? 2'd2 : 2'd1;
            default:                    s = 2'd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pbfmt_decode.sv
module pbfmt_decode
    import pbfmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] fmt_byte,
    input  logic              ext_mode,
    output logic              err_now,
    output pb_cfg_t           cfg_q
);

    logic [CODE_W-1:0] code;
    pb_cfg_t           cfg_d;

    always_comb begin
        code = ext_mode ? fmt_byte[7:5] : {1'b0, fmt_byte[6:5]};
        cfg_d.rate_hz = rate_of(fmt_byte[0], fmt_byte[3:1]);
        cfg_d.stereo  = fmt_byte[4];
        cfg_d.enc     = enc_of(code);
        cfg_d.shift   = shift_of(cfg_d.enc, cfg_d.stereo);
        cfg_d.err     = (cfg_d.rate_hz == '0) || (cfg_d.enc == ENC_NONE);
    end

    assign err_now = cfg_d.err;

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= CFG_RESET;
        else     cfg_q <= cfg_d;
    end

    // R4
    base_mode_no_be_chk: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !ext_mode) |-> (cfg_q.enc != ENC_S16BE));

endmodule

// File: rtl/pbfmt_run_ctl.sv
module pbfmt_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic play_en,
    input  logic err_now,
    output logic start,
    output logic running
);

    logic run_d;

    assign run_d = play_en && !err_now;
    assign start = run_d && !running;

    always_ff @(posedge clk) begin
        if (rst) running <= 1'b0;
        else     running <= run_d;
    end

    // R8
    stop_on_disable_chk: assert property (@(posedge clk) disable iff (rst)
        !play_en |=> !running);

endmodule

// File: rtl/pbfmt_period_cnt.sv
module pbfmt_period_cnt
    import pbfmt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               run,
    input  logic               byte_ack,
    input  logic               irq_en,
    input  logic [BASE_W-1:0]  base,
    input  logic [SHIFT_W-1:0] shift,
    output logic               irq
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] thr;

    assign thr     = CNT_W'(base) << shift;
    assign cnt_inc = cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (start) begin
                cnt_q <= '0;
            end else if (run && byte_ack) begin
                if (irq_en && (cnt_inc == thr)) begin
                    cnt_q <= '0;
                    irq   <= 1'b1;
                end else begin
                    cnt_q <= cnt_inc;
                end
            end
        end
    end

    // R9
    irq_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(byte_ack && run));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(irq_en));

    // R8
    start_clears_cnt_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt_q == '0));

endmodule

// File: rtl/pbfmt_pacer.sv
module pbfmt_pacer
    import pbfmt_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic [7:0]   fmt_byte,
    input  logic         ext_mode,
    input  logic [7:0]   base_hi,
    input  logic [7:0]   base_lo,
    input  logic         irq_en,
    input  logic         play_en,
    input  logic         byte_ack,
    output logic [15:0]  rate_hz,
    output logic         stereo,
    output logic [2:0]   sample_enc,
    output logic [1:0]   byte_shift,
    output logic         cfg_err,
    output logic         dreq,
    output logic         period_irq
);

    pb_cfg_t cfg_q;
    logic    err_now;
    logic    start;
    logic    running;

    pbfmt_decode u_decode (
        .clk      (clk),
        .rst      (rst),
        .fmt_byte (fmt_byte),
        .ext_mode (ext_mode),
        .err_now  (err_now),
        .cfg_q    (cfg_q)
    );

    pbfmt_run_ctl u_run (
        .clk     (clk),
        .rst     (rst),
        .play_en (play_en),
        .err_now (err_now),
        .start   (start),
        .running (running)
    );

    pbfmt_period_cnt u_cnt (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .run      (running),
        .byte_ack (byte_ack),
        .irq_en   (irq_en),
        .base     ({base_hi, base_lo}),
        .shift    (cfg_q.shift),
        .irq      (period_irq)
    );

    assign rate_hz    = cfg_q.rate_hz;
    assign stereo     = cfg_q.stereo;
    assign sample_enc = cfg_q.enc;
    assign byte_shift = cfg_q.shift;
    assign cfg_err    = cfg_q.err;
    assign dreq       = running;

    // R6
    err_blocks_dreq_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> !dreq);

endmodule

// File: tb/tb_pbfmt_pacer.sv
module tb_pbfmt_pacer;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  fmt_byte;
    logic        ext_mode;
    logic [7:0]  base_hi;
    logic [7:0]  base_lo;
    logic        irq_en;
    logic        play_en;
    logic        byte_ack;
    logic [15:0] rate_hz;
    logic        stereo;
    logic [2:0]  sample_enc;
    logic [1:0]  byte_shift;
    logic        cfg_err;
    logic        dreq;
    logic        period_irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pbfmt_pacer dut (
        .clk(clk), .rst(rst), .fmt_byte(fmt_byte), .ext_mode(ext_mode),
        .base_hi(base_hi), .base_lo(base_lo), .irq_en(irq_en),
        .play_en(play_en), .byte_ack(byte_ack), .rate_hz(rate_hz),
        .stereo(stereo), .sample_enc(sample_enc), .byte_shift(byte_shift),
        .cfg_err(cfg_err), .dreq(dreq), .period_irq(period_irq)
    );

    typedef struct packed {
        logic        ext;
        logic [7:0]  fmt;
        logic [15:0] rate;
        logic        st;
        logic [2:0]  enc;
        logic [1:0]  sh;
        logic        err;
    } tb_vec_t;

    localparam int NV = 24;
    localparam tb_vec_t VEC [NV] = '{
        '{1'b0, 8'h00, 16'd8000,  1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h36, 16'd32000, 1'b1, 3'd1, 2'd1, 1'b0},
        '{1'b0, 8'h6C, 16'd48000, 1'b0, 3'd2, 2'd0, 1'b0},
        '{1'b0, 8'h5F, 16'd6620,  1'b1, 3'd3, 2'd2, 1'b0},
        '{1'b0, 8'hC0, 16'd8000,  1'b0, 3'd3, 2'd1, 1'b0}, // R4 bit7 ignored
        '{1'b1, 8'hC0, 16'd8000,  1'b0, 3'd4, 2'd1, 1'b0}, // R4 code 6
        '{1'b1, 8'hD0, 16'd8000,  1'b1, 3'd4, 2'd2, 1'b0},
        '{1'b1, 8'h80, 16'd8000,  1'b0, 3'd7, 2'd0, 1'b1},
        '{1'b1, 8'hA0, 16'd8000,  1'b0, 3'd7, 2'd0, 1'b1},
        '{1'b1, 8'hE0, 16'd8000,  1'b0, 3'd7, 2'd0, 1'b1},
        '{1'b0, 8'h08, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
        '{1'b0, 8'h0A, 16'd0,     1'b0, 3'd0, 2'd0, 1'b1},
        '{1'b0, 8'h09, 16'd37800, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h1B, 16'd44100, 1'b1, 3'd0, 2'd1, 1'b0},
        '{1'b0, 8'h01, 16'd5510,  1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h03, 16'd11025, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h05, 16'd18900, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h07, 16'd22050, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h0D, 16'd33075, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h02, 16'd16000, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h04, 16'd27420, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h0E, 16'd9000,  1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b0, 8'h06, 16'd32000, 1'b0, 3'd0, 2'd0, 1'b0},
        '{1'b1, 8'h30, 16'd8000,  1'b1, 3'd1, 2'd1, 1'b0}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One accepted byte; the pulse it may cause is visible on return.
    task automatic send_byte();
        byte_ack = 1'b1;
        @(negedge clk);
        byte_ack = 1'b0;
    endtask

    // Send n bytes, expecting a pulse only after the last one when hit is set.
    task automatic run_period(input string tag, input int n, input bit hit);
        for (int i = 1; i <= n; i++) begin
            send_byte();
            check(tag, period_irq, (hit && i == n) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; fmt_byte = 8'h00; ext_mode = 1'b0; base_hi = 8'h00;
        base_lo = 8'h03; irq_en = 1'b1; play_en = 1'b0; byte_ack = 1'b0;
        repeat (3) @(negedge clk);
        // R1 during reset
        check("R1 dreq", dreq, 0);
        check("R1 irq", period_irq, 0);
        check("R1 err", cfg_err, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 dreq after", dreq, 0);
        check("R1 irq after", period_irq, 0);

        // Decode table sweep: R2 R3 R4 R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            ext_mode = VEC[k].ext;
            fmt_byte = VEC[k].fmt;
            @(negedge clk);
            check($sformatf("R2 rate v%0d", k), rate_hz, VEC[k].rate);
            check($sformatf("R3 stereo v%0d", k), stereo, VEC[k].st);
            check($sformatf("R5 enc v%0d", k), sample_enc, VEC[k].enc);
            check($sformatf("R7 shift v%0d", k), byte_shift, VEC[k].sh);
            check($sformatf("R6 err v%0d", k), cfg_err, VEC[k].err);
        end

        // R8 start: mono 8-bit, base 3
        ext_mode = 1'b0; fmt_byte = 8'h00; base_lo = 8'h03; play_en = 1'b1;
        @(negedge clk);
        check("R8 dreq rise", dreq, 1);
        // R9 period of 3 bytes, twice
        run_period("R9 mono8 p1", 3, 1'b1);
        @(negedge clk);
        check("R9 pulse width", period_irq, 0);
        run_period("R9 mono8 p2", 3, 1'b1);

        // R8 stop
        play_en = 1'b0;
        @(negedge clk);
        check("R8 dreq fall", dreq, 0);

        // R7 R9 stereo 16-bit: shift 2, base 3 -> 12 bytes
        fmt_byte = 8'h50; play_en = 1'b1;
        @(negedge clk);
        check("R8 dreq restart", dreq, 1);
        run_period("R9 st16", 12, 1'b1);

        // R10 interrupt disabled
        irq_en = 1'b0;
        run_period("R10 no irq", 20, 1'b0);

        // Restart with count reset
        play_en = 1'b0; irq_en = 1'b1;
        @(negedge clk);
        fmt_byte = 8'h00; base_lo = 8'h04; play_en = 1'b1;
        @(negedge clk);
        // R11 format change mid-period keeps count
        run_period("R11 pre", 2, 1'b0);
        fmt_byte = 8'h0C;
        @(negedge clk);
        check("R11 dreq held", dreq, 1);
        check("R11 rate", rate_hz, 48000);
        run_period("R11 post", 2, 1'b1);

        // R6 R8 error stops playback, recovery restarts count
        run_period("R8 pre err", 2, 1'b0);
        fmt_byte = 8'h08;
        @(negedge clk);
        check("R8 err drop", dreq, 0);
        check("R6 err flag", cfg_err, 1);
        run_period("R8 ignored", 2, 1'b0);
        fmt_byte = 8'h00;
        @(negedge clk);
        check("R8 recover", dreq, 1);
        run_period("R8 fresh count", 4, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule